// File: doc/BRIEF.md
# Calendar Shadow Register Read-Lock

This block sits between a free-running calendar and a bus reader. It holds three shadow copies of the calendar: subsecond, time of day and date. All three copies are reloaded together from the live counters whenever a periodic update strobe arrives. A reader that walks the three registers in the order subsecond, time, date therefore sees one coherent snapshot. The first two reads freeze the shadows that the reader has not yet fetched, and the date read lifts the freeze.

An update strobe that arrives while a freeze is held is not lost. It is kept as pending, and every shadow is refreshed from the live counters in the first cycle with no freeze. A bypass input turns the shadows off for reading. Reads then return the live counters directly, and no freeze is taken.

A subsecond read that falls in the same cycle as an update strobe, or one cycle before it, takes effect at once. The strobe cannot slip past the freeze.

Top module: `cal_shadow_lock`

## Requirements
- R1: With bypass low, a read of the subsecond register (address 0) freezes all three shadows. Later time and date reads return values from the same refresh as the subsecond value.
- R2: With bypass low, a read of the time register (address 1) freezes the shadows. A later date read returns the date from the same refresh as that time value.
- R3: A subsecond read in the same cycle as an update strobe, or in the cycle just before it, still freezes the shadows. That strobe changes no shadow until the freeze is released.
- R4: With bypass high, a read returns the live counter of the addressed register, sampled in the read cycle. No freeze is taken, and any freeze already held is dropped.
- R5: With bypass low, a read of the date register (address 2) releases every freeze from the next cycle on.
- R6: A strobe that arrives during a freeze is remembered. Every shadow is reloaded from the live counters in the first cycle after the freeze ends.
- R7: One strobe with no freeze reloads all three shadows in the same clock edge from the live values present in the strobe cycle.
- R8: Synchronous active-high reset clears all three shadows to zero and releases all freezes. Shadow reads after reset return zero.
- R9: Read data and the read-valid flag are registered. They appear in the cycle after `rd_en`, with the value zero-extended to the bus width. Address 3 returns zero, and `rd_valid` is low in any cycle after a cycle with no read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bypass_en | input | 1 | Reads return live counters and take no freeze |
| upd_strobe | input | 1 | Request to reload all shadows from the live counters |
| live_sub | input | SUB_W | Live subsecond counter |
| live_time | input | TIME_W | Live time-of-day counter |
| live_date | input | DATE_W | Live date counter |
| rd_en | input | 1 | Read request, one cycle |
| rd_addr | input | 2 | 0 subsecond, 1 time, 2 date, 3 unused |
| rd_data | output | DATA_W | Registered read data, zero-extended |
| rd_valid | output | 1 | High in the cycle after a read |

## Verification
The hardest case to reach is a subsecond read that meets an update strobe in the same cycle, or one cycle before it. A pending strobe must then survive the freeze and be applied on release. The bench drives those alignments directly as directed cycle sequences. It follows them with a long stream where the strobe, read, address and bypass inputs all come from a shift register, so every ordering of read, strobe and release occurs many times. The live counters change on every cycle. Any read that returns a stale or early value therefore differs from the expected value, which the bench computes from the requirements.

// File: rtl/cal_shadow_pkg.sv
package cal_shadow_pkg;
  typedef enum logic [1:0] {
    REG_SUB  = 2'd0,
    REG_TIME = 2'd1,
    REG_DATE = 2'd2,
    REG_NONE = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/cal_lock_ctrl.sv
module cal_lock_ctrl
  import cal_shadow_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       bypass_en,
  input  logic       rd_en,
  input  logic [1:0] rd_sel,
  input  logic       upd_strobe,
  output logic       lock_time_o,
  output logic       lock_date_o,
  output logic       hold_o,
  output logic       apply_o
);
  logic lock_time_q, lock_date_q, pend_q;
  logic shadow_rd, rd_sub, rd_time, rd_date;

  assign shadow_rd = rd_en && !bypass_en;
  assign rd_sub    = shadow_rd && (rd_sel == REG_SUB);
  assign rd_time   = shadow_rd && (rd_sel == REG_TIME);
  assign rd_date   = shadow_rd && (rd_sel == REG_DATE);

  // a read that freezes acts in its own cycle, so a coincident strobe is held off
  assign hold_o  = lock_time_q | lock_date_q | rd_sub | rd_time;
  assign apply_o = (upd_strobe | pend_q) & ~hold_o;

  always_ff @(posedge clk) begin
    if (rst) begin
      lock_time_q <= 1'b0;
      lock_date_q <= 1'b0;
      pend_q      <= 1'b0;
    end else begin
      if (bypass_en) begin
        lock_time_q <= 1'b0;
        lock_date_q <= 1'b0;
      end else if (rd_sub) begin
        lock_time_q <= 1'b1;
        lock_date_q <= 1'b1;
      end else if (rd_time) begin
        lock_date_q <= 1'b1;
      end else if (rd_date) begin
        lock_time_q <= 1'b0;
        lock_date_q <= 1'b0;
      end
      pend_q <= (upd_strobe | pend_q) & hold_o;
    end
  end

  assign lock_time_o = lock_time_q;
  assign lock_date_o = lock_date_q;

  p_sub_locks_r1: assert property (@(posedge clk) disable iff (rst)
    rd_sub |=> (lock_time_q && lock_date_q));
  p_time_locks_r2: assert property (@(posedge clk) disable iff (rst)
    rd_time |=> lock_date_q);
  p_bypass_free_r4: assert property (@(posedge clk) disable iff (rst)
    bypass_en |=> (!lock_time_q && !lock_date_q));
  p_date_release_r5: assert property (@(posedge clk) disable iff (rst)
    rd_date |=> (!lock_time_q && !lock_date_q));
  p_strobe_kept_r6: assert property (@(posedge clk) disable iff (rst)
    (upd_strobe && hold_o) |=> pend_q);
endmodule

// File: rtl/cal_shadow_reg.sv
module cal_shadow_reg #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] live_i,
  output logic [W-1:0] shadow_o
);
  always_ff @(posedge clk) begin
    if (rst)       shadow_o <= '0;
    else if (load) shadow_o <= live_i;
  end
endmodule

// File: rtl/cal_read_port.sv
module cal_read_port
  import cal_shadow_pkg::*;
#(
  parameter int SUB_W  = 15,
  parameter int TIME_W = 22,
  parameter int DATE_W = 24,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bypass_en,
  input  logic              rd_en,
  input  logic [1:0]        rd_sel,
  input  logic [SUB_W-1:0]  sh_sub,
  input  logic [TIME_W-1:0] sh_time,
  input  logic [DATE_W-1:0] sh_date,
  input  logic [SUB_W-1:0]  live_sub,
  input  logic [TIME_W-1:0] live_time,
  input  logic [DATE_W-1:0] live_date,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid
);
  logic [DATA_W-1:0] sel_d;

  always_comb begin
    case (rd_sel)
      REG_SUB:  sel_d = bypass_en ? DATA_W'(live_sub)  : DATA_W'(sh_sub);
      REG_TIME: sel_d = bypass_en ? DATA_W'(live_time) : DATA_W'(sh_time);
      REG_DATE: sel_d = bypass_en ? DATA_W'(live_date) : DATA_W'(sh_date);
      default:  sel_d = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data  <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= rd_en;
      if (rd_en) rd_data <= sel_d;
    end
  end

  p_valid_follows_r9: assert property (@(posedge clk) disable iff (rst)
    rd_en |=> rd_valid);
  p_valid_idle_r9: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> !rd_valid);
endmodule

// File: rtl/cal_shadow_lock.sv
module cal_shadow_lock #(
  parameter int SUB_W  = 15,
  parameter int TIME_W = 22,
  parameter int DATE_W = 24,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bypass_en,
  input  logic              upd_strobe,
  input  logic [SUB_W-1:0]  live_sub,
  input  logic [TIME_W-1:0] live_time,
  input  logic [DATE_W-1:0] live_date,
  input  logic              rd_en,
  input  logic [1:0]        rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid
);
  logic lock_t, lock_d, hold, apply;
  logic [SUB_W-1:0]  sh_sub;
  logic [TIME_W-1:0] sh_time;
  logic [DATE_W-1:0] sh_date;

  cal_lock_ctrl u_ctrl (
    .clk(clk), .rst(rst), .bypass_en(bypass_en), .rd_en(rd_en),
    .rd_sel(rd_addr), .upd_strobe(upd_strobe),
    .lock_time_o(lock_t), .lock_date_o(lock_d),
    .hold_o(hold), .apply_o(apply)
  );

  cal_shadow_reg #(.W(SUB_W)) u_sh_sub (
    .clk(clk), .rst(rst), .load(apply), .live_i(live_sub), .shadow_o(sh_sub));
  cal_shadow_reg #(.W(TIME_W)) u_sh_time (
    .clk(clk), .rst(rst), .load(apply), .live_i(live_time), .shadow_o(sh_time));
  cal_shadow_reg #(.W(DATE_W)) u_sh_date (
    .clk(clk), .rst(rst), .load(apply), .live_i(live_date), .shadow_o(sh_date));

  cal_read_port #(
    .SUB_W(SUB_W), .TIME_W(TIME_W), .DATE_W(DATE_W), .DATA_W(DATA_W)
  ) u_rd (
    .clk(clk), .rst(rst), .bypass_en(bypass_en), .rd_en(rd_en), .rd_sel(rd_addr),
    .sh_sub(sh_sub), .sh_time(sh_time), .sh_date(sh_date),
    .live_sub(live_sub), .live_time(live_time), .live_date(live_date),
    .rd_data(rd_data), .rd_valid(rd_valid)
  );

  p_hold_blocks_r3: assert property (@(posedge clk) disable iff (rst)
    hold |=> ($stable(sh_sub) && $stable(sh_time) && $stable(sh_date)));
  p_together_r7: assert property (@(posedge clk) disable iff (rst)
    apply |=> (sh_sub == $past(live_sub) && sh_time == $past(live_time)
               && sh_date == $past(live_date)));
  p_reset_r8: assert property (@(posedge clk)
    rst |=> (sh_sub == '0 && sh_time == '0 && sh_date == '0 && !lock_t && !lock_d));
endmodule

// File: tb/cal_shadow_lock_tb_top.sv
`timescale 1ns/1ps
module cal_shadow_lock_tb_top;
  localparam int SW = 15, TW = 22, DW = 24, XW = 32;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;

  logic bypass_en = 0, upd_strobe = 0, rd_en = 0;
  logic [1:0] rd_addr = 0;
  logic [SW-1:0] live_sub = 0;
  logic [TW-1:0] live_time = 0;
  logic [DW-1:0] live_date = 0;
  logic [XW-1:0] rd_data;
  logic rd_valid;

  cal_shadow_lock #(.SUB_W(SW), .TIME_W(TW), .DATE_W(DW), .DATA_W(XW)) dut_i (
    .clk(clk), .rst(rst), .bypass_en(bypass_en), .upd_strobe(upd_strobe),
    .live_sub(live_sub), .live_time(live_time), .live_date(live_date),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .rd_valid(rd_valid));

  int checks = 0, errors = 0;
  logic [31:0] cnt = 0;
  logic [SW-1:0] m_sub = 0;
  logic [TW-1:0] m_time = 0;
  logic [DW-1:0] m_date = 0;
  bit m_lt = 0, m_ld = 0, m_pend = 0;

  task automatic chk(input string req, input logic [XW-1:0] act, input logic [XW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // one bus cycle; expected values follow the requirement rules
  task automatic step(input string req, input bit stb, input bit rd,
                      input logic [1:0] a, input bit byp);
    logic [XW-1:0] exp_d;
    bit hold;
    upd_strobe = stb; rd_en = rd; rd_addr = a; bypass_en = byp;
    cnt = cnt + 1;
    live_sub  = SW'(cnt * 5 + 1);
    live_time = TW'(cnt * 977 + 3);
    live_date = DW'(cnt * 40503 + 7);
    @(posedge clk);
    case (a)
      2'd0: exp_d = byp ? XW'(live_sub)  : XW'(m_sub);
      2'd1: exp_d = byp ? XW'(live_time) : XW'(m_time);
      2'd2: exp_d = byp ? XW'(live_date) : XW'(m_date);
      default: exp_d = '0;
    endcase
    hold = m_lt || m_ld || (rd && !byp && (a == 2'd0 || a == 2'd1));
    if ((stb || m_pend) && !hold) begin
      m_sub = live_sub; m_time = live_time; m_date = live_date;
    end
    m_pend = (stb || m_pend) && hold;
    if (byp) begin m_lt = 0; m_ld = 0; end
    else if (rd && a == 2'd0) begin m_lt = 1; m_ld = 1; end
    else if (rd && a == 2'd1) m_ld = 1;
    else if (rd && a == 2'd2) begin m_lt = 0; m_ld = 0; end
    @(negedge clk);
    chk({req, " R9 valid"}, XW'(rd_valid), XW'(rd));
    if (rd) chk(req, rd_data, exp_d);
    upd_strobe = 0; rd_en = 0;
  endtask

  initial begin
    #(200000 * 4);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] lf;
    logic [XW-1:0] snap;
    repeat (3) @(negedge clk);
    rst = 0;
    // R8: shadows read zero after reset although live counters move
    for (int k = 0; k < 3; k++) step("R8 reset", 0, 1, 2'(k), 0);
    chk("R8 direct zero", rd_data, '0);
    // R7: one strobe, all three shadows from the strobe cycle
    step("R7 strobe", 1, 0, 0, 0);
    snap = XW'(DW'(cnt * 40503 + 7));
    step("R7 sub", 0, 1, 0, 0);
    step("R7 time", 0, 1, 1, 0);
    step("R7 date", 0, 1, 2, 0);
    chk("R7 date from strobe cycle", rd_data, snap);
    // R1: sub read, strobes during freeze, time/date from same refresh
    step("R1 refresh", 1, 0, 0, 0);
    step("R1 sub", 0, 1, 0, 0);
    step("R1 strobe locked", 1, 0, 0, 0);
    step("R1 time", 0, 1, 1, 0);
    step("R1 strobe locked", 1, 0, 0, 0);
    step("R1 date", 0, 1, 2, 0);
    // R6: pending strobe applied after release, R5 release
    step("R6 sub after release", 0, 1, 0, 0);
    step("R5 date", 0, 1, 2, 0);
    // R2: time read freezes date
    step("R2 refresh", 1, 0, 0, 0);
    step("R2 time", 0, 1, 1, 0);
    step("R2 strobe", 1, 0, 0, 0);
    step("R2 date", 0, 1, 2, 0);
    step("R6 applied", 0, 1, 1, 0);
    step("R5 date", 0, 1, 2, 0);
    // R3: sub read coincident with strobe, then one cycle before strobe
    step("R3 same cycle", 1, 1, 0, 0);
    step("R3 time", 0, 1, 1, 0);
    step("R3 date", 0, 1, 2, 0);
    step("R3 sub early", 0, 1, 0, 0);
    step("R3 strobe next", 1, 0, 0, 0);
    step("R3 time", 0, 1, 1, 0);
    step("R3 date", 0, 1, 2, 0);
    step("R6 sub", 0, 1, 0, 0);
    // R4: bypass reads live, takes no freeze, drops held one
    step("R4 lock first", 0, 1, 0, 0);
    for (int k = 0; k < 3; k++) step("R4 bypass", 0, 1, 2'(k), 1);
    step("R4 no lock strobe", 1, 0, 0, 0);
    step("R4 time updated", 0, 1, 1, 0);
    step("R5 date", 0, 1, 2, 0);
    // R9: unused address
    step("R9 addr3", 0, 1, 3, 0);
    step("R9 idle", 0, 0, 0, 0);
    // sweep of all orderings
    lf = 16'hACE1;
    for (int n = 0; n < 3000; n++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      step("R6 sweep", lf[0] & lf[3], lf[1] | lf[5], lf[7:6], lf[9] & lf[11] & lf[2]);
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule